// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block sits in front of a true two-port word memory and settles what happens when both ports aim at the same word in the same clock cycle. Each port has an enable, a read/write select, an address, an upper-half select, a lower-half select and a write data word. Each port gets back registered read data and an active-low busy flag. When both enabled ports present equal addresses, one port is granted and the other sees busy low. The loser's write in that cycle is dropped. Reads are never blocked, so two ports reading one word both get the data.

A strap input picks the mode. In master mode the busy flags come from the local arbiter. In slave mode they mirror externally supplied busy inputs, so a second device can follow a master's decision when words are built wider from several devices. In slave mode a write is dropped whenever its port's external busy is low. The storage is a plain behavioural array with one bank per half-word. Each half is written only when its select is set.

The arbiter is a three-state machine. ARB_FREE means no collision was granted last cycle. ARB_LEFT means the left port won last cycle. ARB_RIGHT means the right port won last cycle.
- From ARB_FREE, a live address match goes to ARB_RIGHT if the right port already held that address in the previous cycle and the left port did not. Otherwise it goes to ARB_LEFT, which is the simultaneous-arrival case where the left port wins.
- ARB_LEFT and ARB_RIGHT stay put while the match lasts. They return to ARB_FREE on the first cycle without a match.
- With no match, ARB_FREE stays in ARB_FREE.

Top module: `twin_port_guard`

## Requirements
- R1: While reset is active and directly after it, both busy outputs are high (inactive) and both read data outputs are 0.
- R2: Accesses of two enabled ports to different addresses raise no busy, and both ports' writes and reads take effect.
- R3: In master mode (mstr_mode=1), when both ports arrive at the same address in the same cycle with neither having held it the cycle before, the right busy goes low in that cycle, the left busy stays high, and only the left write is stored.
- R4: Two reads of the same address in the same cycle both return the stored word, even though one port sees busy.
- R5: In master mode, a port that was enabled at an address in the previous cycle keeps the grant when the other port arrives there. The newcomer sees busy low and its write is dropped.
- R6: In master mode, the loser's busy stays low for exactly one cycle after the match ends, then goes high. A write made by that port during this extra cycle to a different address is stored.
- R7: A port whose enable is low never sees busy low, and it never causes busy on the other port.
- R8: In slave mode (mstr_mode=0), each enabled port's busy output equals its external busy input and local arbitration has no effect. A write with the external busy input low is not stored.
- R9: A write changes only the halves of the word selected by the upper select (bits 15:8) and the lower select (bits 7:0).
- R10: Read data appears one clock after a read request, and it holds its value in cycles without a read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mstr_mode | input | 1 | 1 = busy computed locally, 0 = busy taken from external inputs |
| lp_en | input | 1 | Left port enable |
| lp_wr | input | 1 | Left port write (1) or read (0) |
| lp_ub | input | 1 | Left upper half select |
| lp_lb | input | 1 | Left lower half select |
| lp_addr | input | AW | Left word address |
| lp_wdata | input | DW | Left write data |
| lp_busy_in_n | input | 1 | Left external busy, used in slave mode |
| lp_busy_n | output | 1 | Left busy, active low |
| lp_rdata | output | DW | Left read data |
| rp_en | input | 1 | Right port enable |
| rp_wr | input | 1 | Right port write (1) or read (0) |
| rp_ub | input | 1 | Right upper half select |
| rp_lb | input | 1 | Right lower half select |
| rp_addr | input | AW | Right word address |
| rp_wdata | input | DW | Right write data |
| rp_busy_in_n | input | 1 | Right external busy, used in slave mode |
| rp_busy_n | output | 1 | Right busy, active low |
| rp_rdata | output | DW | Right read data |

## Verification
A wrong arbiter state shows up as a busy flag on the wrong port, or as a busy tail that is missing or too long. Either is visible at the busy outputs within the same cycle or the one after the collision. A wrong grant also lets the losing write through or blocks the winner's write. That shows up as a wrong word on the next read of the contested address, one cycle after that read is issued. Wrong address history breaks the keep-the-grant case in the first collision cycle.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ARB_FREE  = 2'd0,
        ARB_LEFT  = 2'd1,
        ARB_RIGHT = 2'd2
    } arb_state_t;

endpackage

// File: rtl/tpg_arbiter.sv
module tpg_arbiter
    import tpg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mstr_mode,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          l_ext_busy_n,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    input  logic          r_ext_busy_n,
    output logic          l_busy_n,
    output logic          r_busy_n,
    output logic          l_block,
    output logic          r_block
);

    arb_state_t    state_q, state_d;
    logic          l_prev_vld, r_prev_vld;
    logic [AW-1:0] l_prev_addr, r_prev_addr;
    logic          match, l_kept, r_kept, win_right;
    logic          l_loc, r_loc, l_blk_loc, r_blk_loc;

    assign match  = l_en && r_en && (l_addr == r_addr);
    assign l_kept = l_prev_vld && (l_prev_addr == l_addr);
    assign r_kept = r_prev_vld && (r_prev_addr == r_addr);

    // Grant decision for a live match: right wins only if it won last cycle
    // or it alone already sat on this address
    always_comb begin
        unique case (state_q)
            ARB_LEFT:  win_right = 1'b0;
            ARB_RIGHT: win_right = 1'b1;
            default:   win_right = r_kept && !l_kept;
        endcase
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (match) state_d = win_right ? ARB_RIGHT : ARB_LEFT;
            end
            ARB_LEFT: begin
                if (!match) state_d = ARB_FREE;
            end
            ARB_RIGHT: begin
                if (!match) state_d = ARB_FREE;
            end
            default: state_d = ARB_FREE;
        endcase
    end

    // State and address history registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ARB_FREE;
            l_prev_vld  <= 1'b0;
            r_prev_vld  <= 1'b0;
            l_prev_addr <= '0;
            r_prev_addr <= '0;
        end else begin
            state_q     <= state_d;
            l_prev_vld  <= l_en;
            r_prev_vld  <= r_en;
            l_prev_addr <= l_addr;
            r_prev_addr <= r_addr;
        end
    end

    // Output process: local busy covers the live collision and one tail cycle
    always_comb begin
        l_blk_loc = match && win_right;
        r_blk_loc = match && !win_right;
        unique case (state_q)
            ARB_LEFT: begin
                l_loc = 1'b0;
                r_loc = 1'b1;
            end
            ARB_RIGHT: begin
                l_loc = 1'b1;
                r_loc = 1'b0;
            end
            default: begin
                l_loc = l_blk_loc;
                r_loc = r_blk_loc;
            end
        endcase
        if (mstr_mode) begin
            l_busy_n = !(l_en && l_loc);
            r_busy_n = !(r_en && r_loc);
            l_block  = l_blk_loc;
            r_block  = r_blk_loc;
        end else begin
            l_busy_n = !(l_en && !l_ext_busy_n);
            r_busy_n = !(r_en && !r_ext_busy_n);
            l_block  = !l_ext_busy_n;
            r_block  = !r_ext_busy_n;
        end
    end

    // R3: never both ports busy in master mode
    p_one_loser_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mstr_mode |-> (l_busy_n || r_busy_n));

    // R3: fresh simultaneous arrival goes to the left port
    p_left_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mstr_mode && match && state_q == ARB_FREE && !r_kept) |-> (!r_busy_n && l_busy_n));

    // R7: a disabled port never sees busy
    p_idle_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en |-> l_busy_n);
    p_idle_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_en |-> r_busy_n);

    // R6: two cycles without a match leave both flags released
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mstr_mode && $past(mstr_mode) && !match && !$past(match)) |-> (l_busy_n && r_busy_n));

endmodule

// File: rtl/tpg_lane_ram.sv
module tpg_lane_ram #(
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_we,
    input  logic             l_re,
    input  logic [LANES-1:0] l_be,
    input  logic [AW-1:0]    l_addr,
    input  logic [DW-1:0]    l_wd,
    output logic [DW-1:0]    l_q,
    input  logic             r_we,
    input  logic             r_re,
    input  logic [LANES-1:0] r_be,
    input  logic [AW-1:0]    r_addr,
    input  logic [DW-1:0]    r_wd,
    output logic [DW-1:0]    r_q
);

    localparam int LW    = DW / LANES;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] bank [DEPTH];
        logic [LW-1:0] lq, rq;

        // Left write applied first, right write last on the same word
        always_ff @(posedge clk) begin
            if (l_we && l_be[g]) bank[l_addr] <= l_wd[g*LW +: LW];
            if (r_we && r_be[g]) bank[r_addr] <= r_wd[g*LW +: LW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lq <= '0;
                rq <= '0;
            end else begin
                if (l_re) lq <= bank[l_addr];
                if (r_re) rq <= bank[r_addr];
            end
        end

        assign l_q[g*LW +: LW] = lq;
        assign r_q[g*LW +: LW] = rq;
    end

    // R10: read data holds when the port issued no read
    p_hold_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(l_re) |-> $stable(l_q));
    p_hold_right_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(r_re) |-> $stable(r_q));

endmodule

// File: rtl/twin_port_guard.sv
module twin_port_guard #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mstr_mode,
    input  logic          lp_en,
    input  logic          lp_wr,
    input  logic          lp_ub,
    input  logic          lp_lb,
    input  logic [AW-1:0] lp_addr,
    input  logic [DW-1:0] lp_wdata,
    input  logic          lp_busy_in_n,
    output logic          lp_busy_n,
    output logic [DW-1:0] lp_rdata,
    input  logic          rp_en,
    input  logic          rp_wr,
    input  logic          rp_ub,
    input  logic          rp_lb,
    input  logic [AW-1:0] rp_addr,
    input  logic [DW-1:0] rp_wdata,
    input  logic          rp_busy_in_n,
    output logic          rp_busy_n,
    output logic [DW-1:0] rp_rdata
);

    localparam int LANES = 2;

    logic             l_block, r_block;
    logic             l_we, r_we, l_re, r_re;
    logic [LANES-1:0] l_be, r_be;

    tpg_arbiter #(.AW(AW)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .mstr_mode    (mstr_mode),
        .l_en         (lp_en),
        .l_addr       (lp_addr),
        .l_ext_busy_n (lp_busy_in_n),
        .r_en         (rp_en),
        .r_addr       (rp_addr),
        .r_ext_busy_n (rp_busy_in_n),
        .l_busy_n     (lp_busy_n),
        .r_busy_n     (rp_busy_n),
        .l_block      (l_block),
        .r_block      (r_block)
    );

    assign l_we = lp_en && lp_wr && !l_block;
    assign r_we = rp_en && rp_wr && !r_block;
    assign l_re = lp_en && !lp_wr;
    assign r_re = rp_en && !rp_wr;
    assign l_be = {lp_ub, lp_lb};
    assign r_be = {rp_ub, rp_lb};

    tpg_lane_ram #(.AW(AW), .DW(DW), .LANES(LANES)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_we   (l_we),
        .l_re   (l_re),
        .l_be   (l_be),
        .l_addr (lp_addr),
        .l_wd   (lp_wdata),
        .l_q    (lp_rdata),
        .r_we   (r_we),
        .r_re   (r_re),
        .r_be   (r_be),
        .r_addr (rp_addr),
        .r_wd   (rp_wdata),
        .r_q    (rp_rdata)
    );

    // R8: an externally busied write never reaches the array in slave mode
    p_slave_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mstr_mode && !lp_busy_in_n && lp_en && lp_wr) |-> !l_we);

    // R3: a port reported busy in a live collision never writes
    p_loser_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mstr_mode && !rp_busy_n && lp_en && rp_en && lp_addr == rp_addr) |-> !r_we);

endmodule

// File: tb/sim_twin_port_guard.sv
`timescale 1ns/1ps
module sim_twin_port_guard;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NV = 11;

    typedef struct packed {
        logic          le;
        logic          lw;
        logic [1:0]    lbe;
        logic [AW-1:0] la;
        logic [DW-1:0] ld;
        logic          re;
        logic          rw;
        logic [1:0]    rbe;
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        logic          elb;
        logic          erb;
        logic          cl;
        logic [DW-1:0] eld;
        logic          cr;
        logic [DW-1:0] erd;
    } vec_t;

    // Master mode vectors: drive, expected busy in that cycle, expected read data after it
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,2'b11,6'd1,16'h1111, 1'b1,1'b1,2'b11,6'd2,16'h2222, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000},
        '{1'b1,1'b0,2'b11,6'd2,16'h0000, 1'b1,1'b0,2'b11,6'd1,16'h0000, 1'b1,1'b1, 1'b1,16'h2222, 1'b1,16'h1111},
        '{1'b1,1'b1,2'b11,6'd3,16'hAAAA, 1'b1,1'b1,2'b11,6'd3,16'hBBBB, 1'b1,1'b0, 1'b0,16'h0000, 1'b0,16'h0000},
        '{1'b1,1'b0,2'b11,6'd3,16'h0000, 1'b1,1'b0,2'b11,6'd1,16'h0000, 1'b1,1'b0, 1'b1,16'hAAAA, 1'b1,16'h1111},
        '{1'b1,1'b0,2'b11,6'd3,16'h0000, 1'b1,1'b0,2'b11,6'd3,16'h0000, 1'b1,1'b0, 1'b1,16'hAAAA, 1'b1,16'hAAAA},
        '{1'b0,1'b0,2'b00,6'd3,16'h0000, 1'b0,1'b0,2'b00,6'd3,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000},
        '{1'b1,1'b1,2'b11,6'd5,16'h1234, 1'b0,1'b0,2'b00,6'd0,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000},
        '{1'b0,1'b0,2'b00,6'd0,16'h0000, 1'b1,1'b1,2'b01,6'd5,16'hFF56, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000},
        '{1'b1,1'b0,2'b11,6'd5,16'h0000, 1'b0,1'b0,2'b00,6'd0,16'h0000, 1'b1,1'b1, 1'b1,16'h1256, 1'b0,16'h0000},
        '{1'b1,1'b1,2'b10,6'd5,16'h9900, 1'b0,1'b0,2'b00,6'd0,16'h0000, 1'b1,1'b1, 1'b1,16'h1256, 1'b0,16'h0000},
        '{1'b0,1'b0,2'b00,6'd0,16'h0000, 1'b1,1'b0,2'b11,6'd5,16'h0000, 1'b1,1'b1, 1'b1,16'h1256, 1'b1,16'h9956}
    };
    string vtag [NV] = '{"R2", "R2", "R3", "R6", "R4", "R7", "R9", "R9", "R9", "R10", "R9"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mstr_mode = 1'b1;
    logic          lp_en = 1'b0, lp_wr = 1'b0, lp_ub = 1'b0, lp_lb = 1'b0;
    logic [AW-1:0] lp_addr = '0;
    logic [DW-1:0] lp_wdata = '0;
    logic          lp_busy_in_n = 1'b1;
    logic          lp_busy_n;
    logic [DW-1:0] lp_rdata;
    logic          rp_en = 1'b0, rp_wr = 1'b0, rp_ub = 1'b0, rp_lb = 1'b0;
    logic [AW-1:0] rp_addr = '0;
    logic [DW-1:0] rp_wdata = '0;
    logic          rp_busy_in_n = 1'b1;
    logic          rp_busy_n;
    logic [DW-1:0] rp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twin_port_guard #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mstr_mode(mstr_mode),
        .lp_en(lp_en), .lp_wr(lp_wr), .lp_ub(lp_ub), .lp_lb(lp_lb),
        .lp_addr(lp_addr), .lp_wdata(lp_wdata), .lp_busy_in_n(lp_busy_in_n),
        .lp_busy_n(lp_busy_n), .lp_rdata(lp_rdata),
        .rp_en(rp_en), .rp_wr(rp_wr), .rp_ub(rp_ub), .rp_lb(rp_lb),
        .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_busy_in_n(rp_busy_in_n),
        .rp_busy_n(rp_busy_n), .rp_rdata(rp_rdata)
    );

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check busy 1 ns later, return at the next falling edge
    task automatic cyc(input logic le, input logic lw, input logic [1:0] lbe, input logic [AW-1:0] la,
                       input logic [DW-1:0] ld, input logic re, input logic rw, input logic [1:0] rbe,
                       input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                       input string tag, input logic elb, input logic erb);
        lp_en = le; lp_wr = lw; {lp_ub, lp_lb} = lbe; lp_addr = la; lp_wdata = ld;
        rp_en = re; rp_wr = rw; {rp_ub, rp_lb} = rbe; rp_addr = ra; rp_wdata = rd;
        #1;
        chk(tag, "left busy", {15'd0, lp_busy_n}, {15'd0, elb});
        chk(tag, "right busy", {15'd0, rp_busy_n}, {15'd0, erb});
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "left busy in reset", {15'd0, lp_busy_n}, 16'd1);
        chk("R1", "right busy in reset", {15'd0, rp_busy_n}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "left rdata after reset", lp_rdata, 16'h0000);
        chk("R1", "right rdata after reset", rp_rdata, 16'h0000);
        chk("R1", "left busy after reset", {15'd0, lp_busy_n}, 16'd1);

        // Vector table in master mode
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].le, VEC[i].lw, VEC[i].lbe, VEC[i].la, VEC[i].ld,
                VEC[i].re, VEC[i].rw, VEC[i].rbe, VEC[i].ra, VEC[i].rd,
                vtag[i], VEC[i].elb, VEC[i].erb);
            if (VEC[i].cl) chk(vtag[i], "left rdata", lp_rdata, VEC[i].eld);
            if (VEC[i].cr) chk(vtag[i], "right rdata", rp_rdata, VEC[i].erd);
        end

        // R5: right holds address 9, left arrives later and loses
        cyc(1,1,2'b11,6'd9,16'h0909, 0,0,2'b00,6'd0,16'h0, "R5", 1, 1);
        cyc(0,0,2'b00,6'd0,16'h0,    1,0,2'b11,6'd9,16'h0, "R5", 1, 1);
        cyc(1,1,2'b11,6'd9,16'hDEAD, 1,0,2'b11,6'd9,16'h0, "R5", 0, 1);
        chk("R5", "holder reads old word", rp_rdata, 16'h0909);
        // R6: tail cycle, left moved to address 10 and its write is stored
        cyc(1,1,2'b11,6'd10,16'h0A0A, 1,0,2'b11,6'd9,16'h0, "R6", 0, 1);
        cyc(1,0,2'b11,6'd9,16'h0,     1,0,2'b11,6'd10,16'h0, "R6", 1, 1);
        chk("R5", "late write dropped", lp_rdata, 16'h0909);
        chk("R6", "tail write stored", rp_rdata, 16'h0A0A);

        // R7: disabled right port at the same address raises no busy
        cyc(1,1,2'b11,6'd11,16'h1B1B, 0,1,2'b11,6'd11,16'hFFFF, "R7", 1, 1);
        cyc(1,0,2'b11,6'd11,16'h0,    0,0,2'b00,6'd0,16'h0,     "R7", 1, 1);
        chk("R7", "left write stored", lp_rdata, 16'h1B1B);

        // R3: simultaneous writes, only the left word kept
        cyc(1,1,2'b11,6'd12,16'h0C0C, 1,1,2'b11,6'd12,16'hEEEE, "R3", 1, 0);
        cyc(0,0,2'b00,6'd0,16'h0,     1,0,2'b11,6'd13,16'h0,     "R6", 1, 0);
        cyc(0,0,2'b00,6'd0,16'h0,     1,0,2'b11,6'd12,16'h0,     "R6", 1, 1);
        chk("R3", "left word won", rp_rdata, 16'h0C0C);

        // R8: slave mode follows external busy only
        mstr_mode = 1'b1;
        cyc(1,1,2'b11,6'd7,16'h0101, 0,0,2'b00,6'd0,16'h0, "R8", 1, 1);
        mstr_mode = 1'b0;
        lp_busy_in_n = 1'b0;
        cyc(1,1,2'b11,6'd7,16'h7777, 0,0,2'b00,6'd0,16'h0, "R8", 0, 1);
        lp_busy_in_n = 1'b1;
        cyc(1,1,2'b11,6'd8,16'h0808, 1,0,2'b11,6'd8,16'h0, "R8", 1, 1);
        rp_busy_in_n = 1'b0;
        cyc(0,0,2'b00,6'd0,16'h0,    1,0,2'b11,6'd7,16'h0, "R8", 1, 0);
        rp_busy_in_n = 1'b1;
        chk("R8", "busied write dropped", rp_rdata, 16'h0101);
        cyc(0,0,2'b00,6'd0,16'h0,    1,0,2'b11,6'd8,16'h0, "R8", 1, 1);
        chk("R8", "unblocked write stored", rp_rdata, 16'h0808);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule